// File: doc/BRIEF.md
# SPI Master with Automatic Inter-Word Gap

This block is a single-data-lane SPI master. Software-side logic loads words into a transmit queue. The block shifts each word out MSB first on the serial line and shifts the incoming bits into a receive queue. The word length can be chosen at runtime. After every word the block holds the bus idle on its own for a programmable number of source-clock cycles, so a slow slave has time to absorb the word before the next one begins. The serial clock comes from a prescaler on the source clock. Both clock polarity and clock phase are selectable, which covers all four SPI modes.

A 3-wire option lets transmit and receive share one data line. In that mode the direction input decides whether the block drives the line (its output-enable is high) or listens to it. Chip select is held asserted while the software enable is set and for as long as a burst is in flight. The block flags activity with `busy` and gives a one-cycle `done` pulse when the last gap of a burst has expired and the transmit queue is empty.

Configuration inputs are captured when each word is loaded. They should be changed only while the block is idle.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, `cs_n` is 1, `busy` is 0, `done` is 0, `rx_valid` is 0, `tx_full` is 0 and `sclk` sits at the `cpol` level (0 after reset).
- R2: While a word is shifting, every `sclk` half period lasts `prescale + 1` source cycles, giving SCLK = src / (2·(prescale+1)). When no word is shifting, `sclk` rests at `cpol`.
- R3: The effective word length is derived from `word_len`. A value of 1 to 8 gives 8 bits, 9 to 16 gives 16 bits and 17 to 32 gives 32 bits. The values 0 and 33 to 63 have no legal meaning and fall back to 8 bits. Each word produces exactly 2·length `sclk` edges.
- R4: `mosi` carries the low `length` bits of each transmit word, MSB first. With CPHA=0 the MSB is on the line before the first edge and each next bit appears on a trailing edge. With CPHA=1 each bit is valid at the trailing edge where the slave samples it.
- R5: The master samples the data input on leading edges when CPHA=0 and on trailing edges when CPHA=1. Each received word is assembled MSB first, zero-extended to 32 bits, and written to the receive queue when its last bit is sampled.
- R6: The first `sclk` edge of a following word comes exactly (4·`gap_count` + 10) + (`prescale` + 1) source cycles after the last edge of the previous word. The range of `gap_count` is 0 to 31.
- R7: `cs_n` goes low when a burst starts and stays low through every inter-word gap. It stays low after the burst while `cs_en` is 1. It returns to 1 on the clock after `cs_en` is cleared while idle.
- R8: `busy` is 1 from the loading of the first word until the final gap expires. `done` pulses for exactly one cycle, in the cycle `busy` falls, once per burst.
- R9: With `three_wire`=1 and `hd_rx`=1, `mosi_oe` is 0 and received bits come from `sdio_i`. With `three_wire`=1 and `hd_rx`=0, `mosi_oe` is 1 and nothing is written to the receive queue. With `three_wire`=0, `mosi_oe` is 1 and bits come from `miso`.
- R10: While `cs_en` is 0, queued words are not sent: `sclk` stays at `cpol`, `busy` stays 0 and `cs_n` stays 1. The queued words go out once `cs_en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 32 | Transmit word (low `length` bits are sent) |
| tx_full | output | 1 | Transmit queue is full |
| rx_pop | input | 1 | Remove the head word of the receive queue |
| rx_data | output | 32 | Head word of the receive queue |
| rx_valid | output | 1 | Receive queue holds at least one word |
| prescale | input | 8 | Clock prescaler P, SCLK = src/(2·(P+1)) |
| gap_count | input | 5 | Gap count N, idle of 4·N+10 cycles after each word |
| word_len | input | 6 | Requested word length, rounded as in R3 |
| cpol | input | 1 | Clock polarity, idle level of `sclk` |
| cpha | input | 1 | Clock phase, 0 = sample on leading edge |
| three_wire | input | 1 | Share one data line for both directions |
| hd_rx | input | 1 | In 3-wire mode, 1 = receive direction |
| cs_en | input | 1 | Chip-select enable, permits transfers |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Drive enable for the data-out line |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in (4-wire mode) |
| sdio_i | input | 1 | Shared data line input (3-wire mode) |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
A wrong edge counter or a wrong length decode shows up within one word as too many or too few `sclk` edges. It also corrupts every word after it, because the bench slave shifts in lockstep. A prescaler or gap counter that is off by one shows up as soon as two edges or two words are on the bus, as a wrong spacing between `sclk` edges. A mistake in phase handling or in the shift register shows up at the end of the first word as a mismatched `mosi` word or a mismatched received word. A state-machine fault around the gap shows up at the end of the burst as a missing or doubled `done`, or as `cs_n` rising during a gap.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_e;

    // Rounds a requested length up to a supported size; illegal values give 8.
    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] req);
        logic [LEN_W-1:0] r;
        if (req == '0 || req > LEN_W'(32)) begin
            r = LEN_W'(8);
        end else if (req > LEN_W'(16)) begin
            r = LEN_W'(32);
        end else if (req > LEN_W'(8)) begin
            r = LEN_W'(16);
        end else begin
            r = LEN_W'(8);
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_gap_fifo.sv
module spi_gap_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_t;

    fifo_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d     = q;
        empty = (q.count == '0);
        full  = (q.count == CW'(DEPTH));
        do_wr = push && !full;
        do_rd = pop && !empty;
        if (do_wr) d.wr_ptr = nxt(q.wr_ptr);
        if (do_rd) d.rd_ptr = nxt(q.rd_ptr);
        case ({do_wr, do_rd})
            2'b10:   d.count = q.count + CW'(1);
            2'b01:   d.count = q.count - CW'(1);
            default: d.count = q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wr_ptr] <= wdata;
    end

    assign rdata = mem[q.rd_ptr];

    AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full); // R10

endmodule

// File: rtl/spi_gap_tick.sv
module spi_gap_tick #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d    = q;
        tick = en && (q.cnt == limit);
        if (!en || tick) d.cnt = '0;
        else             d.cnt = q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0 && $stable(limit)) |=> !tick); // R2

endmodule

// File: rtl/spi_gap_engine.sv
module spi_gap_engine
    import spi_gap_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int GAP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [GAP_W-1:0]  gap_count,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              three_wire,
    input  logic              hd_rx,
    input  logic              cs_en,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              tick,
    output logic              shift_en,
    output logic [PRE_W-1:0]  pre_cur,
    input  logic              miso,
    input  logic              sdio_i,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              mosi_oe,
    output logic              cs_n,
    output logic              busy,
    output logic              done
);
    localparam int GAP_CYC_W = GAP_W + 3;
    localparam int EDGE_W    = LEN_W + 1;

    typedef struct packed {
        eng_state_e         st;
        logic               sclk;
        logic [EDGE_W-1:0]  edge_cnt;
        logic [GAP_CYC_W-1:0] gap_cnt;
        logic [GAP_W-1:0]   gap;
        logic [PRE_W-1:0]   pre;
        logic [DATA_W-1:0]  tx_sr;
        logic [DATA_W-1:0]  rx_sr;
        logic [LEN_W-1:0]   wlen;
        logic               cpha;
        logic               tw;
        logic               rx_en;
        logic               oe;
        logic               done;
        logic               cs_n;
    } eng_t;

    eng_t q, d;

    logic [GAP_CYC_W-1:0] gap_len;
    logic [EDGE_W-1:0]    e_n, two_w, last_samp;
    logic [LEN_W-1:0]     len_new;
    logic                 do_load, start_ok, din, samp_edge, shift_edge;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        tx_pop     = 1'b0;
        rx_push    = 1'b0;
        do_load    = 1'b0;
        samp_edge  = 1'b0;
        shift_edge = 1'b0;
        start_ok   = cs_en && !tx_empty;
        len_new    = eff_len(word_len);
        gap_len    = GAP_CYC_W'({q.gap, 2'b00}) + GAP_CYC_W'(10);
        two_w      = {q.wlen, 1'b0};
        last_samp  = q.cpha ? two_w : two_w - EDGE_W'(1);
        e_n        = q.edge_cnt + EDGE_W'(1);
        din        = q.tw ? sdio_i : miso;

        case (q.st)
            ST_IDLE: begin
                d.sclk = cpol;
                d.oe   = !(three_wire && hd_rx);
                if (start_ok) do_load = 1'b1;
            end
            ST_SHIFT: begin
                if (tick) begin
                    d.sclk     = ~q.sclk;
                    d.edge_cnt = e_n;
                    samp_edge  = q.cpha ? !e_n[0] : e_n[0];
                    if (q.cpha) shift_edge = e_n[0] && (e_n != EDGE_W'(1));
                    else        shift_edge = !e_n[0] && (e_n != two_w);
                    if (samp_edge) begin
                        d.rx_sr = {q.rx_sr[DATA_W-2:0], din};
                        if (e_n == last_samp && q.rx_en) rx_push = 1'b1;
                    end
                    if (shift_edge) d.tx_sr = {q.tx_sr[DATA_W-2:0], 1'b0};
                    if (e_n == two_w) begin
                        d.st      = ST_GAP;
                        d.gap_cnt = '0;
                    end
                end
            end
            ST_GAP: begin
                d.gap_cnt = q.gap_cnt + GAP_CYC_W'(1);
                if (q.gap_cnt == gap_len - GAP_CYC_W'(1)) begin
                    if (start_ok) begin
                        do_load = 1'b1;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.sclk = cpol;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (do_load) begin
            tx_pop     = 1'b1;
            d.st       = ST_SHIFT;
            d.sclk     = cpol;
            d.edge_cnt = '0;
            d.wlen     = len_new;
            d.cpha     = cpha;
            d.pre      = prescale;
            d.gap      = gap_count;
            d.tw       = three_wire;
            d.rx_en    = !(three_wire && !hd_rx);
            d.oe       = !(three_wire && hd_rx);
            d.rx_sr    = '0;
            d.tx_sr    = tx_data << (DATA_W - int'(len_new));
        end

        d.cs_n  = !(cs_en || d.st != ST_IDLE);
        rx_word = d.rx_sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
            q.oe   <= 1'b1;
            q.wlen <= LEN_W'(8);
        end else begin
            q <= d;
        end
    end

    assign shift_en = (q.st == ST_SHIFT);
    assign pre_cur  = q.pre;
    assign sclk     = q.sclk;
    assign mosi     = q.tx_sr[DATA_W-1];
    assign mosi_oe  = q.oe;
    assign cs_n     = q.cs_n;
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;

    AST_SCLK_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !tx_pop) |=> (sclk == $past(cpol))); // R2

    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT) |-> (q.edge_cnt < two_w)); // R3

    AST_CS_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> !cs_n); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8

    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (q.st == ST_SHIFT && !(q.tw && !q.rx_en))); // R9

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_en && q.st == ST_IDLE) |=> !busy); // R10

endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master
    import spi_gap_pkg::*;
#(
    parameter int PRE_W      = 8,
    parameter int GAP_W      = 5,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [GAP_W-1:0]  gap_count,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              three_wire,
    input  logic              hd_rx,
    input  logic              cs_en,
    output logic              sclk,
    output logic              mosi,
    output logic              mosi_oe,
    output logic              cs_n,
    input  logic              miso,
    input  logic              sdio_i,
    output logic              busy,
    output logic              done
);
    logic              tx_empty, tx_pop;
    logic [DATA_W-1:0] tx_head;
    logic              rx_push, rx_empty, rx_full_unused;
    logic [DATA_W-1:0] rx_word;
    logic              tick, shift_en;
    logic [PRE_W-1:0]  pre_cur;

    spi_gap_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spi_gap_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data),
        .empty(rx_empty), .full(rx_full_unused)
    );

    spi_gap_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .en(shift_en), .limit(pre_cur), .tick(tick)
    );

    spi_gap_engine #(.PRE_W(PRE_W), .GAP_W(GAP_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .prescale(prescale), .gap_count(gap_count), .word_len(word_len),
        .cpol(cpol), .cpha(cpha), .three_wire(three_wire), .hd_rx(hd_rx),
        .cs_en(cs_en),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .tick(tick), .shift_en(shift_en), .pre_cur(pre_cur),
        .miso(miso), .sdio_i(sdio_i),
        .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .cs_n(cs_n),
        .busy(busy), .done(done)
    );

    assign rx_valid = !rx_empty;

    AST_RX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_unused && !rx_pop) |=> !rx_empty); // R5

endmodule

// File: tb/spi_gap_master_tb.sv
module spi_gap_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic [7:0]  prescale = '0;
    logic [4:0]  gap_count = '0;
    logic [5:0]  word_len = 6'd8;
    logic        cpol = 1'b0, cpha = 1'b0, three_wire = 1'b0, hd_rx = 1'b0, cs_en = 1'b0;
    logic        sclk, mosi, mosi_oe, cs_n, busy, done;
    logic        miso_r = 1'b0;

    always #5 clk = ~clk;

    spi_gap_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
        .prescale(prescale), .gap_count(gap_count), .word_len(word_len),
        .cpol(cpol), .cpha(cpha), .three_wire(three_wire), .hd_rx(hd_rx),
        .cs_en(cs_en),
        .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .cs_n(cs_n),
        .miso(miso_r), .sdio_i(miso_r),
        .busy(busy), .done(done)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // bench model of the length rule
    function automatic int exp_len(input int req);
        if (req == 0 || req > 32) return 8;
        if (req > 16) return 32;
        if (req > 8) return 16;
        return 8;
    endfunction

    // smallest prescaler whose rate does not exceed the request
    function automatic int pre_for(input int src_khz, input int req_khz);
        int dv;
        dv = (src_khz + 2 * req_khz - 1) / (2 * req_khz);
        return dv - 1;
    endfunction

    // monitor / slave model state
    bit        mon_en = 0;
    int        cyc = 0, last_t = 0, edge_n = 0, widx = 0, bitpos = 0;
    int        m_w = 8, m_p = 0, m_g = 10;
    bit        m_pha = 0, m_oe_exp = 1;
    bit [31:0] capw;
    bit [31:0] cap_tx [8];
    bit [31:0] slv [8];
    int        half_err = 0, gap_err = 0, cs_err = 0, oe_err = 0, done_cnt = 0;
    logic      prev_sclk = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (done) done_cnt++;
            if (busy && cs_n) cs_err++;
            if (busy && mosi_oe != m_oe_exp) oe_err++;
            if (sclk !== prev_sclk) begin
                if (edge_n > 0) begin
                    if (cyc - last_t != m_p + 1) half_err++;
                end else if (widx > 0) begin
                    if (cyc - last_t != m_g + m_p + 1) gap_err++;
                end
                last_t = cyc;
                edge_n++;
                if (m_pha ? (edge_n % 2 == 0) : (edge_n % 2 == 1))
                    capw = {capw[30:0], mosi};
                if (m_pha ? (edge_n % 2 == 1 && edge_n >= 3)
                          : (edge_n % 2 == 0 && edge_n < 2 * m_w))
                    bitpos++;
                if (edge_n == 2 * m_w) begin
                    if (widx < 8) cap_tx[widx] = capw;
                    widx++;
                    bitpos = 0;
                    edge_n = 0;
                    capw   = '0;
                end
                if (widx < 8) miso_r = slv[widx][m_w - 1 - bitpos];
            end
        end
        prev_sclk = sclk;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1'b1,  "R1", "cs_n after reset", cs_n, 1);
        chk(busy == 1'b0,  "R1", "busy after reset", busy, 0);
        chk(done == 1'b0,  "R1", "done after reset", done, 0);
        chk(rx_valid == 0, "R1", "rx_valid after reset", rx_valid, 0);
        chk(tx_full == 0,  "R1", "tx_full after reset", tx_full, 0);
        chk(sclk == 1'b0,  "R1", "sclk after reset", sclk, 0);
    endtask

    task automatic burst(input string name, input int pre, input int gap, input int lreq,
                         input bit pol, input bit pha, input bit tw, input bit hd,
                         input int n, input bit hold);
        bit [31:0] txw [8];
        bit [31:0] mask;
        int w, wait_c;
        bit rx_exp;
        w      = exp_len(lreq);
        mask   = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        rx_exp = !(tw && !hd);
        @(negedge clk);
        prescale = 8'(pre); gap_count = 5'(gap); word_len = 6'(lreq);
        cpol = pol; cpha = pha; three_wire = tw; hd_rx = hd;
        for (int i = 0; i < n; i++) begin
            txw[i] = (32'h9E37_79B9 * (i + 1)) ^ 32'(lreq * 7);
            slv[i] = {txw[i][15:0], txw[i][31:16]} ^ 32'h5A5A_A5A5;
        end
        m_w = w; m_p = pre; m_g = 4 * gap + 10; m_pha = pha; m_oe_exp = !(tw && hd);
        widx = 0; bitpos = 0; edge_n = 0; capw = '0;
        half_err = 0; gap_err = 0; cs_err = 0; oe_err = 0; done_cnt = 0;
        miso_r = slv[0][w - 1];
        for (int i = 0; i < n; i++) begin
            tx_push = 1'b1; tx_data = txw[i];
            @(negedge clk);
        end
        tx_push = 1'b0;
        repeat (3) @(negedge clk);
        mon_en = 1'b1;
        if (hold) begin
            repeat (60) @(negedge clk);
            chk(sclk == pol, "R10", {name, " sclk while disabled"}, sclk, pol);
            chk(busy == 0,   "R10", {name, " busy while disabled"}, busy, 0);
            chk(cs_n == 1,   "R10", {name, " cs_n while disabled"}, cs_n, 1);
            chk(widx == 0,   "R10", {name, " no word sent while disabled"}, widx, 0);
        end
        chk(sclk == pol, "R2", {name, " sclk idle level"}, sclk, pol);
        cs_en = 1'b1;
        wait_c = 0;
        while (done_cnt == 0 && wait_c < 40000) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (5) @(negedge clk);
        chk(done_cnt == 1, "R8", {name, " done pulse count"}, done_cnt, 1);
        chk(busy == 0,     "R8", {name, " busy after burst"}, busy, 0);
        chk(cs_n == 0,     "R7", {name, " cs_n held while enabled"}, cs_n, 0);
        chk(cs_err == 0,   "R7", {name, " cs_n low through gaps"}, cs_err, 0);
        chk(widx == n && edge_n == 0, "R3", {name, " words of 2*len edges"}, widx, n);
        chk(half_err == 0, "R2", {name, " half period"}, half_err, 0);
        chk(gap_err == 0,  "R6", {name, " inter-word spacing"}, gap_err, 0);
        chk(oe_err == 0,   "R9", {name, " data-out enable"}, oe_err, 0);
        for (int i = 0; i < n && i < 8; i++)
            chk(cap_tx[i] == (txw[i] & mask), "R4", {name, " mosi word"},
                cap_tx[i], txw[i] & mask);
        mon_en = 1'b0;
        cs_en  = 1'b0;
        @(negedge clk);
        chk(cs_n == 1, "R7", {name, " cs_n after disable"}, cs_n, 1);
        if (rx_exp) begin
            for (int i = 0; i < n; i++) begin
                chk(rx_valid == 1, "R5", {name, " rx word present"}, rx_valid, 1);
                chk(rx_data == (slv[i] & mask), "R5", {name, " rx word"},
                    rx_data, slv[i] & mask);
                rx_pop = 1'b1;
                @(negedge clk);
                rx_pop = 1'b0;
            end
        end
        chk(rx_valid == 0, "R9", {name, " rx queue empty"}, rx_valid, 0);
    endtask

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();

        p = pre_for(100000, 30000);
        chk(p == 1, "R2", "rounded-up prescaler", p, 1);
        chk(100000 / (2 * (p + 1)) <= 30000, "R2", "rate not above request",
            100000 / (2 * (p + 1)), 30000);

        burst("mode0_len8",   p, 0,  8,  1'b0, 1'b0, 1'b0, 1'b0, 3, 1'b0);
        burst("mode3_len12",  0, 3,  12, 1'b1, 1'b1, 1'b0, 1'b0, 2, 1'b0);
        burst("mode1_len20",  2, 31, 20, 1'b0, 1'b1, 1'b0, 1'b0, 2, 1'b0);
        burst("mode2_len0",   0, 1,  0,  1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b0);
        burst("len40_hold",   1, 2,  40, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b1);
        burst("len32_full",   0, 0,  32, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0);
        burst("wire3_tx",     1, 0,  16, 1'b0, 1'b0, 1'b1, 1'b0, 2, 1'b0);
        burst("wire3_rx",     0, 5,  9,  1'b1, 1'b1, 1'b1, 1'b1, 2, 1'b0);

        finish_run();
    end

endmodule